// File: doc/BRIEF.md
# DDC Byte FIFO with Threshold Request

This block is the byte buffer between a display data channel (DDC) transfer engine and the register bus that software uses to drive it. Software selects a direction, programs a slave address, a byte count and two 4-bit thresholds, then starts a command. In write direction, software fills the FIFO through a data register and the engine drains it. In read direction, the engine fills it and software drains it.

A request status bit tells software when it is worth servicing the FIFO. It is set while the fill level is above the RX threshold in read direction, or below the TX threshold in write direction. A build parameter makes both comparisons inclusive instead of strict.

The engine side is a pair of push/pop strobes plus done and error inputs. A byte counter loaded at start raises a transfer-complete status bit when the programmed number of engine-side bytes has moved. Status bits are cleared by writing one to them. Two control bits clear themselves one cycle after they are written: a FIFO flush bit and a soft reset bit. The soft reset leaves the slave address untouched.

Top module: `ddc_fifo_ctrl`

## Requirements
- R1: After `rst`, every register reads 0, the FIFO is empty, and `eng_rdata`, `eng_go` and `eng_rd_dir` are 0.
- R2: Status bit 2 (request) is set while the level condition holds and stays set until written 1 with the condition false. In read direction the condition is level > RX threshold (FCTRL[7:4]). In write direction it is level < TX threshold (FCTRL[3:0]). With `INCL_THR`=1 the comparisons are >= and <=.
- R3: The FIFO holds `DEPTH` (16) bytes in first-in first-out order. The head byte shows on `eng_rdata` and on a read of the data register (address 5). Both read 0 when the FIFO is empty.
- R4: A push to a full FIFO or a pop from an empty one is dropped and sets status bit 1 (error).
- R5: Writing 1 to FCTRL bit 31 (address 2) sets a flush bit that reads 1 for one cycle. On the next edge that bit returns to 0 and the FIFO is emptied.
- R6: Writing 1 to CTRL bit 0 (address 0) sets a soft reset bit that reads 1 for one cycle. On the next edge it returns to 0 and clears the FIFO, the status, the thresholds, the byte count, start and direction. Enable (CTRL bit 31) is kept.
- R7: The slave address register (address 1, bits [6:0]) keeps its value through a soft reset.
- R8: Writing the status register (address 3) clears exactly the bits written as 1. Bit 0 is transfer complete, bit 1 is error, bit 2 is request.
- R9: A start loads the 10-bit byte count (address 4) into a counter. Each accepted engine-side beat decrements it. Engine-side beats are pops in write direction and pushes in read direction. The cycle after the counter reaches 0, status bit 0 is set.
- R10: CTRL bit 30 (start) is set only by a write that also sets enable (bit 31). It clears itself when `eng_done` pulses.
- R11: CTRL bit 8 selects the direction, with 1 meaning read. In read direction the engine pushes and software pops. In write direction software pushes and the engine pops. A strobe from the wrong side is ignored.
- R12: A pulse on `eng_err` sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data register) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| eng_push | input | 1 | Engine pushes a received byte |
| eng_wdata | input | 8 | Byte pushed by the engine |
| eng_pop | input | 1 | Engine takes the head byte |
| eng_rdata | output | 8 | Head byte offered to the engine |
| eng_done | input | 1 | Engine finished the command |
| eng_err | input | 1 | Engine reports a bus error |
| eng_go | output | 1 | Start bit towards the engine |
| eng_rd_dir | output | 1 | Direction towards the engine, 1 = read |
| eng_saddr | output | 7 | Slave address towards the engine |

## Verification
The request flag is exercised with a table of direction, threshold and fill level triples. Each triple is placed at, just below or just above a threshold, including the empty and full extremes. Every triple is applied to a strict-compare and an inclusive-compare instance at once, so the equality cases are the ones that separate the two variants. Directed sequences then overfill and over-drain the FIFO, flush it, soft reset it with a live address, and run a counted transfer to completion.

// File: rtl/ddcf_pkg.sv
package ddcf_pkg;
    localparam int REG_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int RADDR_W = 3;
    localparam int SADDR_W = 7;
    localparam int THR_W   = 4;
    localparam int STAT_W  = 9;

    typedef enum logic [RADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_SADDR = 3'd1,
        RA_FCTRL = 3'd2,
        RA_STAT  = 3'd3,
        RA_BCNT  = 3'd4,
        RA_DATA  = 3'd5
    } reg_sel_e;

    localparam int B_EN   = 31;
    localparam int B_GO   = 30;
    localparam int B_DIR  = 8;
    localparam int B_SRST = 0;
    localparam int B_CLR  = 31;
    localparam int B_RXT  = 4;
    localparam int B_TXT  = 0;
    localparam int S_TC   = 0;
    localparam int S_ERR  = 1;
    localparam int S_REQ  = 2;

    typedef struct packed {
        logic en;
        logic go;
        logic rd_dir;
        logic srst;
    } ctrl_t;

    typedef struct packed {
        logic             clr;
        logic [THR_W-1:0] rx;
        logic [THR_W-1:0] tx;
    } fctrl_t;

    typedef struct packed {
        logic req;
        logic err;
        logic tc;
    } stat_t;

    // Reference form of the request condition, used by the checker.
    function automatic logic thr_hit(input logic incl, input logic rd_dir,
                                     input int unsigned lvl,
                                     input int unsigned rx,
                                     input int unsigned tx);
        if (rd_dir)
            return incl ? (lvl >= rx) : (lvl > rx);
        return incl ? (lvl <= tx) : (lvl < tx);
    endfunction
endpackage

// File: rtl/ddcf_fifo.sv
module ddcf_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] lvl,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   lvl <= lvl + 1'b1;
                2'b01:   lvl <= lvl - 1'b1;
                default: lvl <= lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush && !rst) mem[wp] <= din;
    end

    assign full  = (lvl == LW'(DEPTH));
    assign empty = (lvl == '0);
    assign dout  = empty ? '0 : mem[rp];
endmodule

// File: rtl/ddcf_thresh.sv
module ddcf_thresh #(
    parameter bit INCL = 1'b0,
    parameter int LW   = 5,
    parameter int TW   = 4
) (
    input  logic [LW-1:0] lvl,
    input  logic [TW-1:0] rx,
    input  logic [TW-1:0] tx,
    input  logic          rd_dir,
    output logic          hit
);
    logic [LW-1:0] rx_e, tx_e;
    assign rx_e = LW'(rx);
    assign tx_e = LW'(tx);

    generate
        if (INCL) begin : g_incl
            assign hit = rd_dir ? (lvl >= rx_e) : (lvl <= tx_e);
        end else begin : g_excl
            assign hit = rd_dir ? (lvl > rx_e) : (lvl < tx_e);
        end
    endgenerate
endmodule

// File: rtl/ddcf_xfer.sv
module ddcf_xfer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic          beat,
    output logic          busy,
    output logic          done_pulse
);
    logic [CW-1:0] rem;

    assign done_pulse = busy && (rem == '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy <= 1'b0;
            rem  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            rem  <= load_cnt;
        end else if (done_pulse) begin
            busy <= 1'b0;
        end else if (busy && beat) begin
            rem <= rem - 1'b1;
        end
    end
endmodule

// File: rtl/ddc_fifo_ctrl.sv
module ddc_fifo_ctrl
    import ddcf_pkg::*;
#(
    parameter  int DEPTH    = 16,
    parameter  int CNT_W    = 10,
    parameter  bit INCL_THR = 1'b0,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               eng_push,
    input  logic [BYTE_W-1:0]  eng_wdata,
    input  logic               eng_pop,
    output logic [BYTE_W-1:0]  eng_rdata,
    input  logic               eng_done,
    input  logic               eng_err,
    output logic               eng_go,
    output logic               eng_rd_dir,
    output logic [SADDR_W-1:0] eng_saddr
);
    ctrl_t              ctrl;
    fctrl_t             fc;
    stat_t              stat, st_set, st_clr;
    logic [SADDR_W-1:0] saddr;
    logic [CNT_W-1:0]   bcnt;

    logic wr_ctrl, wr_saddr, wr_fc, wr_stat, wr_bcnt, host_dw, host_dr;
    assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
    assign wr_saddr = reg_wr && (reg_addr == RA_SADDR);
    assign wr_fc    = reg_wr && (reg_addr == RA_FCTRL);
    assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
    assign wr_bcnt  = reg_wr && (reg_addr == RA_BCNT);
    assign host_dw  = reg_wr && (reg_addr == RA_DATA);
    assign host_dr  = reg_rd && (reg_addr == RA_DATA);

    // Side selection by direction
    logic              push_req, pop_req, push_ok, pop_ok, fifo_full, fifo_empty;
    logic [BYTE_W-1:0] push_din, fifo_dout;
    logic [LVL_W-1:0]  fifo_lvl;
    logic              fifo_flush, req_hit, err_set, beat, start_wr, busy, done_pulse;

    assign push_req   = ctrl.rd_dir ? eng_push : host_dw;
    assign push_din   = ctrl.rd_dir ? eng_wdata : reg_wdata[BYTE_W-1:0];
    assign pop_req    = ctrl.rd_dir ? host_dr : eng_pop;
    assign push_ok    = push_req && !fifo_full;
    assign pop_ok     = pop_req && !fifo_empty;
    assign err_set    = (push_req && fifo_full) || (pop_req && fifo_empty) || eng_err;
    assign beat       = ctrl.rd_dir ? push_ok : pop_ok;
    assign fifo_flush = fc.clr || ctrl.srst;
    assign start_wr   = wr_ctrl && reg_wdata[B_GO] && reg_wdata[B_EN] && !ctrl.srst;

    ddcf_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst(rst), .flush(fifo_flush),
        .push(push_ok), .pop(pop_ok), .din(push_din),
        .dout(fifo_dout), .lvl(fifo_lvl), .full(fifo_full), .empty(fifo_empty)
    );

    ddcf_thresh #(.INCL(INCL_THR), .LW(LVL_W), .TW(THR_W)) u_thr (
        .lvl(fifo_lvl), .rx(fc.rx), .tx(fc.tx), .rd_dir(ctrl.rd_dir), .hit(req_hit)
    );

    ddcf_xfer #(.CW(CNT_W)) u_xfer (
        .clk(clk), .rst(rst), .flush(ctrl.srst), .load(start_wr),
        .load_cnt(bcnt), .beat(beat), .busy(busy), .done_pulse(done_pulse)
    );

    always_comb begin
        st_set.tc  = done_pulse;
        st_set.err = err_set;
        st_set.req = req_hit;
        st_clr     = '0;
        if (wr_stat) begin
            st_clr.tc  = reg_wdata[S_TC];
            st_clr.err = reg_wdata[S_ERR];
            st_clr.req = reg_wdata[S_REQ];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            fc   <= '0;
            stat <= '0;
            bcnt <= '0;
        end else if (ctrl.srst) begin
            ctrl.go     <= 1'b0;
            ctrl.rd_dir <= 1'b0;
            ctrl.srst   <= 1'b0;
            fc          <= '0;
            stat        <= '0;
            bcnt        <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en     <= reg_wdata[B_EN];
                ctrl.rd_dir <= reg_wdata[B_DIR];
                ctrl.srst   <= reg_wdata[B_SRST];
            end
            if (start_wr)      ctrl.go <= 1'b1;
            else if (eng_done) ctrl.go <= 1'b0;

            if (fc.clr)                         fc.clr <= 1'b0;
            else if (wr_fc && reg_wdata[B_CLR]) fc.clr <= 1'b1;
            if (wr_fc) begin
                fc.rx <= reg_wdata[B_RXT +: THR_W];
                fc.tx <= reg_wdata[B_TXT +: THR_W];
            end

            if (wr_bcnt) bcnt <= reg_wdata[CNT_W-1:0];
            stat <= st_set | (stat & ~st_clr);
        end
    end

    // Address register lies outside the soft reset domain
    always_ff @(posedge clk) begin
        if (rst)           saddr <= '0;
        else if (wr_saddr) saddr <= reg_wdata[SADDR_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[B_EN]   = ctrl.en;
                reg_rdata[B_GO]   = ctrl.go;
                reg_rdata[B_DIR]  = ctrl.rd_dir;
                reg_rdata[B_SRST] = ctrl.srst;
            end
            RA_SADDR: reg_rdata[SADDR_W-1:0] = saddr;
            RA_FCTRL: begin
                reg_rdata[B_CLR]          = fc.clr;
                reg_rdata[B_RXT +: THR_W] = fc.rx;
                reg_rdata[B_TXT +: THR_W] = fc.tx;
            end
            RA_STAT: begin
                reg_rdata[S_TC]  = stat.tc;
                reg_rdata[S_ERR] = stat.err;
                reg_rdata[S_REQ] = stat.req;
            end
            RA_BCNT:  reg_rdata[CNT_W-1:0]  = bcnt;
            RA_DATA:  reg_rdata[BYTE_W-1:0] = fifo_dout;
            default:  reg_rdata = '0;
        endcase
    end

    assign eng_rdata  = fifo_dout;
    assign eng_go     = ctrl.go;
    assign eng_rd_dir = ctrl.rd_dir;
    assign eng_saddr  = saddr;
endmodule

// File: rtl/ddcf_ctrl_chk.sv
module ddcf_ctrl_chk
    import ddcf_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  bit INCL  = 1'b0,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [LW-1:0]      lvl,
    input logic               clr_bit,
    input logic               srst_bit,
    input logic [SADDR_W-1:0] saddr,
    input logic               saddr_wr,
    input logic               req_bit,
    input logic               err_bit,
    input logic               push_req,
    input logic               full,
    input logic               rd_dir,
    input logic [THR_W-1:0]   rx,
    input logic [THR_W-1:0]   tx
);
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
        lvl <= LW'(DEPTH));

    assert_req_set_R2: assert property (@(posedge clk) disable iff (rst)
        (!srst_bit && thr_hit(INCL, rd_dir, 32'(lvl), 32'(rx), 32'(tx))) |=> req_bit);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (!srst_bit && push_req && full) |=> err_bit);

    assert_clear_selfclr_R5: assert property (@(posedge clk) disable iff (rst)
        clr_bit |=> (!clr_bit && lvl == '0));

    assert_srst_selfclr_R6: assert property (@(posedge clk) disable iff (rst)
        srst_bit |=> (!srst_bit && lvl == '0));

    assert_saddr_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (srst_bit && !saddr_wr) |=> $stable(saddr));
endmodule

bind ddc_fifo_ctrl ddcf_ctrl_chk #(.DEPTH(DEPTH), .INCL(INCL_THR)) u_chk (
    .clk(clk), .rst(rst), .lvl(fifo_lvl), .clr_bit(fc.clr), .srst_bit(ctrl.srst),
    .saddr(saddr), .saddr_wr(wr_saddr), .req_bit(stat.req), .err_bit(stat.err),
    .push_req(push_req), .full(fifo_full), .rd_dir(ctrl.rd_dir), .rx(fc.rx), .tx(fc.tx)
);

// File: tb/ddc_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module ddc_fifo_ctrl_tb;
    import ddcf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_x, rdata_i, last_i;
    logic        eng_push = 1'b0, eng_pop = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic [7:0]  eng_wdata = '0;
    logic [7:0]  rdx_eng, rdi_eng;
    logic        go_x, dir_x, go_i, dir_i;
    logic [6:0]  sa_x, sa_i;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ddc_fifo_ctrl #(.INCL_THR(1'b0)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_x), .eng_push(eng_push),
        .eng_wdata(eng_wdata), .eng_pop(eng_pop), .eng_rdata(rdx_eng),
        .eng_done(eng_done), .eng_err(eng_err), .eng_go(go_x), .eng_rd_dir(dir_x),
        .eng_saddr(sa_x)
    );

    ddc_fifo_ctrl #(.INCL_THR(1'b1)) u_dut_inc (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_i), .eng_push(eng_push),
        .eng_wdata(eng_wdata), .eng_pop(eng_pop), .eng_rdata(rdi_eng),
        .eng_done(eng_done), .eng_err(eng_err), .eng_go(go_i), .eng_rd_dir(dir_i),
        .eng_saddr(sa_i)
    );

    // {dir, rx, tx, fill, expect strict, expect inclusive}
    localparam logic [15:0] VEC [9] = '{
        {1'b0, 4'd15, 4'd4, 5'd4,  1'b0, 1'b1},
        {1'b0, 4'd15, 4'd4, 5'd3,  1'b1, 1'b1},
        {1'b0, 4'd15, 4'd4, 5'd5,  1'b0, 1'b0},
        {1'b0, 4'd15, 4'd0, 5'd0,  1'b0, 1'b1},
        {1'b1, 4'd7,  4'd0, 5'd7,  1'b0, 1'b1},
        {1'b1, 4'd7,  4'd0, 5'd8,  1'b1, 1'b1},
        {1'b1, 4'd7,  4'd0, 5'd6,  1'b0, 1'b0},
        {1'b1, 4'd15, 4'd0, 5'd16, 1'b1, 1'b1},
        {1'b1, 4'd15, 4'd0, 5'd15, 1'b0, 1'b1}
    };

    localparam logic [31:0] EN = 32'h8000_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = rdata_x; last_i = rdata_i;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic epush(input logic [7:0] b);
        eng_push = 1'b1; eng_wdata = b;
        @(negedge clk);
        eng_push = 1'b0;
    endtask

    task automatic epop();
        eng_pop = 1'b1;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(RA_CTRL, d);  chk("R1 ctrl", d, 0);
        rd(RA_SADDR, d); chk("R1 saddr", d, 0);
        rd(RA_FCTRL, d); chk("R1 fctrl", d, 0);
        rd(RA_STAT, d);  chk("R1 stat", d, 0);
        rd(RA_BCNT, d);  chk("R1 bcnt", d, 0);
        chk("R1 engine outputs", {21'd0, rdx_eng, go_x, dir_x}, 0);

        // R2 threshold table, strict and inclusive instances side by side
        for (int i = 0; i < 9; i++) begin
            logic [15:0] v;
            v = VEC[i];
            wr(RA_CTRL, {1'b1, 22'd0, v[15], 8'd0});
            wr(RA_FCTRL, {1'b1, 23'd0, v[14:11], v[10:7]});
            @(negedge clk);
            for (int j = 0; j < int'(v[6:2]); j++) begin
                if (v[15]) epush(8'h30 + 8'(j));
                else       wr(RA_DATA, {24'd0, 8'h30 + 8'(j)});
            end
            wr(RA_STAT, 32'h4);
            rd(RA_STAT, d);
            chk($sformatf("R2 strict vec %0d", i), {31'd0, d[S_REQ]}, {31'd0, v[1]});
            chk($sformatf("R2 inclusive vec %0d", i), {31'd0, last_i[S_REQ]}, {31'd0, v[0]});
        end

        // R9 and R10: counted transfer in write direction
        wr(RA_CTRL, EN);
        wr(RA_FCTRL, 32'h8000_0000);
        @(negedge clk);
        wr(RA_STAT, 32'h7);
        wr(RA_BCNT, 32'd3);
        for (int j = 0; j < 3; j++) wr(RA_DATA, 32'h41 + 32'(j));
        wr(RA_CTRL, EN | 32'h4000_0000);
        rd(RA_CTRL, d); chk("R10 start set", d, EN | 32'h4000_0000);
        chk("R11 head to engine", {24'd0, rdx_eng}, 32'h41);
        epop(); epop();
        rd(RA_STAT, d); chk("R9 tc not early", d, 0);
        epop();
        @(negedge clk);
        rd(RA_STAT, d); chk("R9 tc set", d, 32'h1);
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
        rd(RA_CTRL, d); chk("R10 start cleared by done", d, EN);
        wr(RA_CTRL, 32'h4000_0000);
        rd(RA_CTRL, d); chk("R10 start needs enable", d, 0);
        wr(RA_CTRL, EN);

        // R4 overflow, R8 selective clear, R3 ordering and depth
        for (int j = 0; j < 17; j++) wr(RA_DATA, 32'h10 + 32'(j));
        rd(RA_STAT, d); chk("R4 overflow err", d, 32'h3);
        wr(RA_STAT, 32'h2);
        rd(RA_STAT, d); chk("R8 only err cleared", d, 32'h1);
        for (int j = 0; j < 16; j++) begin
            #1;
            chk($sformatf("R3 order byte %0d", j), {24'd0, rdx_eng}, 32'h10 + 32'(j));
            epop();
        end
        chk("R3 empty reads zero", {24'd0, rdx_eng}, 0);
        epop();
        rd(RA_STAT, d); chk("R4 underflow err", d, 32'h3);

        // R11 read direction: engine fills, software drains
        wr(RA_CTRL, EN | 32'h100);
        wr(RA_FCTRL, 32'h8000_0000);
        @(negedge clk);
        wr(RA_STAT, 32'h7);
        wr(RA_DATA, 32'h99);
        rd(RA_STAT, d); chk("R11 wrong side write ignored", d, 0);
        for (int j = 0; j < 5; j++) epush(8'hA0 + 8'(j));
        for (int j = 0; j < 5; j++) begin
            rd(RA_DATA, d); chk($sformatf("R11 read byte %0d", j), d, 32'hA0 + 32'(j));
        end
        wr(RA_STAT, 32'h7);
        rd(RA_DATA, d); chk("R3 empty data read", d, 0);
        rd(RA_STAT, d); chk("R4 read underflow err", {31'd0, d[S_ERR]}, 1);

        // R5 flush bit
        wr(RA_CTRL, EN);
        for (int j = 0; j < 3; j++) wr(RA_DATA, 32'h61 + 32'(j));
        wr(RA_FCTRL, 32'h8000_0000);
        rd(RA_FCTRL, d); chk("R5 flush bit visible", d, 32'h8000_0000);
        rd(RA_FCTRL, d); chk("R5 flush bit self-clears", d, 0);
        chk("R5 fifo emptied", {24'd0, rdx_eng}, 0);

        // R12 engine error
        wr(RA_STAT, 32'h7);
        eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
        rd(RA_STAT, d); chk("R12 engine err", {31'd0, d[S_ERR]}, 1);

        // R6 and R7 soft reset
        wr(RA_SADDR, 32'h50);
        wr(RA_FCTRL, 32'h32);
        wr(RA_BCNT, 32'd9);
        wr(RA_DATA, 32'h77);
        wr(RA_CTRL, EN | 32'h1);
        rd(RA_CTRL, d);  chk("R6 reset bit visible", d, EN | 32'h1);
        rd(RA_CTRL, d);  chk("R6 reset bit self-clears", d, EN);
        rd(RA_SADDR, d); chk("R7 address kept", d, 32'h50);
        chk("R7 address on port", {25'd0, sa_x}, 32'h50);
        rd(RA_FCTRL, d); chk("R6 thresholds cleared", d, 0);
        rd(RA_BCNT, d);  chk("R6 count cleared", d, 0);
        rd(RA_STAT, d);  chk("R6 status cleared", d, 0);
        chk("R6 fifo emptied", {24'd0, rdx_eng}, 0);

        summary();
    end
endmodule